// File: doc/BRIEF.md
# Decoded Micro-op Cache

This block keeps the micro-op groups produced by an instruction decoder so that a later fetch of the same address can skip decoding. Fetch logic presents an address on the lookup port before decode begins. One cycle after the lookup is accepted, the block reports the outcome. On a hit it raises a decoder-off signal and streams the stored micro-ops, one per beat, on a valid/ready output. On a miss the decoder is left running, and every group it produces is written back through the fill port.

Storage is direct-mapped: the low bits of the fetch address select one entry, and the upper bits are kept as a tag. A fill always overwrites its entry. The cache must hold only addresses that the first-level instruction cache still holds, so each eviction notice from that cache removes every entry whose address falls in the evicted line. A flush input empties the whole cache at once.

A two-state controller runs the output side. In `ST_IDLE` it accepts lookups. The transition `IDLE_TO_SEND` happens when an accepted lookup hits. In `ST_SEND` it presents micro-ops. The transition `SEND_TO_IDLE` happens when the final micro-op of the group is taken. A miss leaves the controller in `ST_IDLE`.

Top module: `uop_cache`

## Requirements
- R1: An address selects entry `addr[IDX_W-1:0]` and is tagged with `addr[AW-1:IDX_W]`. A fill to an address that shares the index of a stored address replaces it, so a later lookup of the older address misses.
- R2: Every fill is stored. A lookup accepted at a clock edge that finds a valid entry with a matching tag raises `res_valid_o` and `dec_off_o` together for the one cycle after that edge.
- R3: A lookup that misses raises `res_valid_o` with `dec_off_o` low for one cycle, and no micro-op is presented.
- R4: `fill_cnt_i` = k stores k+1 micro-ops, where micro-op j is `fill_uops_i[j*UW +: UW]`. On a hit, the micro-ops go out in order j = 0..k, starting in the cycle that `dec_off_o` is high, and `uop_last_o` is high only on micro-op k.
- R5: While `uop_valid_o` is high and `uop_ready_i` is low, `uop_valid_o`, `uop_data_o` and `uop_last_o` hold their values. Each stored micro-op is delivered exactly once per hit.
- R6: `lk_ready_o` is low whenever micro-ops are being presented, and high in `ST_IDLE`.
- R7: An eviction with line number L (`evict_line_i`) invalidates every entry whose address satisfies `addr[AW-1:LINE_W]` == L. Entries in other lines stay valid.
- R8: `flush_i` invalidates every entry in one cycle.
- R9: When a lookup and a fill target the same index in the same cycle, the lookup misses and the fill is stored.
- R10: `flush_i` overrides eviction, and eviction overrides a fill to an address in the evicted line. A lookup made in the same cycle as a flush, or as an eviction covering its entry, misses.
- R11: After reset, no entry is valid, `lk_ready_o` is high, and `uop_valid_o` and `res_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all entries |
| lk_valid_i | input | 1 | Lookup request |
| lk_ready_o | output | 1 | Lookup can be accepted |
| lk_addr_i | input | AW | Fetch address to look up |
| res_valid_o | output | 1 | Lookup outcome is valid (one cycle) |
| dec_off_o | output | 1 | Hit: turn the decoder off for this fetch |
| fill_valid_i | input | 1 | Decoder group write |
| fill_addr_i | input | AW | Fetch address of the decoded group |
| fill_cnt_i | input | CNT_W | Micro-op count minus one |
| fill_uops_i | input | MAXU*UW | Packed micro-ops, slot j at j*UW |
| evict_valid_i | input | 1 | Instruction-cache eviction notice |
| evict_line_i | input | AW-LINE_W | Evicted line number |
| uop_valid_o | output | 1 | Micro-op present |
| uop_ready_i | input | 1 | Consumer takes the micro-op |
| uop_data_o | output | UW | Micro-op word |
| uop_last_o | output | 1 | Final micro-op of the group |

## Verification
The assertions assume that reset is held for at least one clock edge, and that a consumer's ready signal is the only thing that may stall the output stream. They do not require the fill and eviction inputs to avoid any particular cycle. The stimulus changes inputs only away from the active edge, and it presents a lookup only while `lk_ready_o` is high. Same-cycle collisions between lookup, fill, eviction and flush are created on purpose to reach the priority rules.

// File: rtl/uopc_pkg.sv
package uopc_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } uopc_state_e;
endpackage

// File: rtl/uopc_array.sv
module uopc_array #(
    parameter int AW     = 16,
    parameter int IDX_W  = 4,
    parameter int LINE_W = 2,
    parameter int UW     = 16,
    parameter int MAXU   = 4,
    parameter int CNT_W  = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               flush_i,
    input  logic               evict_valid_i,
    input  logic [AW-LINE_W-1:0] evict_line_i,
    input  logic               fill_valid_i,
    input  logic [AW-1:0]      fill_addr_i,
    input  logic [CNT_W-1:0]   fill_cnt_i,
    input  logic [MAXU*UW-1:0] fill_uops_i,
    input  logic               lk_fire_i,
    input  logic [AW-1:0]      lk_addr_i,
    output logic               hit_o,
    output logic [CNT_W-1:0]   hit_cnt_o,
    output logic [MAXU*UW-1:0] hit_uops_o
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int TAG_W = AW - IDX_W;

    logic [DEPTH-1:0]   valid_q;
    logic [TAG_W-1:0]   tag_q  [DEPTH];
    logic [CNT_W-1:0]   cnt_q  [DEPTH];
    logic [MAXU*UW-1:0] uops_q [DEPTH];
    logic [DEPTH-1:0]   ev_hit;

    logic [IDX_W-1:0] fill_idx, lk_idx;
    logic             fill_in_ev;

    assign fill_idx   = fill_addr_i[IDX_W-1:0];
    assign lk_idx     = lk_addr_i[IDX_W-1:0];
    assign fill_in_ev = evict_valid_i && (fill_addr_i[AW-1:LINE_W] == evict_line_i);

    // Each entry checks whether its own address falls in the evicted line
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [AW-1:0] ent_addr;
        assign ent_addr  = {tag_q[i], IDX_W'(i)};
        assign ev_hit[i] = evict_valid_i && (ent_addr[AW-1:LINE_W] == evict_line_i);

        // R7: an eviction covering this entry leaves it invalid unless a fill rewrites it
        a_r7_evict_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (ev_hit[i] && valid_q[i] && !(fill_valid_i && fill_idx == IDX_W'(i)))
            |=> !valid_q[i]);
    end

    // Valid bits: flush over eviction over fill (R8, R10)
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            valid_q <= '0;
        end else if (flush_i) begin
            valid_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (fill_valid_i && fill_idx == IDX_W'(i))
                    valid_q[i] <= !fill_in_ev;
                else if (ev_hit[i])
                    valid_q[i] <= 1'b0;
            end
        end
    end

    // Payload: every decoded group is written (R2)
    always_ff @(posedge clk_i) begin
        if (fill_valid_i) begin
            tag_q[fill_idx]  <= fill_addr_i[AW-1:IDX_W];
            cnt_q[fill_idx]  <= fill_cnt_i;
            uops_q[fill_idx] <= fill_uops_i;
        end
    end

    // Lookup: a same-cycle fill to the index, a flush or a covering eviction forces a miss (R9, R10)
    assign hit_o = lk_fire_i && valid_q[lk_idx]
                 && (tag_q[lk_idx] == lk_addr_i[AW-1:IDX_W])
                 && !flush_i && !ev_hit[lk_idx]
                 && !(fill_valid_i && fill_idx == lk_idx);
    assign hit_cnt_o  = cnt_q[lk_idx];
    assign hit_uops_o = uops_q[lk_idx];

    // R8: a flush empties the array in one cycle
    a_r8_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> (valid_q == '0));
endmodule

// File: rtl/uopc_stream.sv
module uopc_stream
    import uopc_pkg::*;
#(
    parameter int UW    = 16,
    parameter int MAXU  = 4,
    parameter int CNT_W = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               lk_valid_i,
    output logic               lk_ready_o,
    output logic               lk_fire_o,
    input  logic               hit_i,
    input  logic [CNT_W-1:0]   hit_cnt_i,
    input  logic [MAXU*UW-1:0] hit_uops_i,
    output logic               res_valid_o,
    output logic               dec_off_o,
    output logic               uop_valid_o,
    input  logic               uop_ready_i,
    output logic [UW-1:0]      uop_data_o,
    output logic               uop_last_o
);
    uopc_state_e state_q, state_d;

    logic             res_valid_q, hit_q;
    logic [CNT_W-1:0] beat_q, cnt_q;
    logic [UW-1:0]    buf_q [MAXU];

    assign lk_ready_o = (state_q == ST_IDLE);
    assign lk_fire_o  = lk_valid_i && lk_ready_o;

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // Transitions: IDLE_TO_SEND on a hit, SEND_TO_IDLE on the final beat taken
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (lk_fire_o && hit_i) state_d = ST_SEND;
            ST_SEND: if (uop_ready_i && beat_q == cnt_q) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Lookup outcome and beat counter
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            res_valid_q <= 1'b0;
            hit_q       <= 1'b0;
            beat_q      <= '0;
            cnt_q       <= '0;
        end else begin
            res_valid_q <= lk_fire_o;
            hit_q       <= lk_fire_o && hit_i;
            if (lk_fire_o && hit_i) begin
                beat_q <= '0;
                cnt_q  <= hit_cnt_i;
            end else if (state_q == ST_SEND && uop_ready_i) begin
                beat_q <= beat_q + CNT_W'(1);
            end
        end
    end

    // Captured micro-op words
    always_ff @(posedge clk_i) begin
        if (lk_fire_o && hit_i) begin
            for (int j = 0; j < MAXU; j++) buf_q[j] <= hit_uops_i[j*UW +: UW];
        end
    end

    // Outputs
    assign res_valid_o = res_valid_q;
    assign dec_off_o   = res_valid_q && hit_q;
    assign uop_valid_o = (state_q == ST_SEND);
    assign uop_data_o  = buf_q[beat_q];
    assign uop_last_o  = (beat_q == cnt_q);

    // R5: stalled output holds
    a_r5_hold_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (uop_valid_o && !uop_ready_i) |=> (uop_valid_o && $stable(uop_data_o) && $stable(uop_last_o)));
    // R6: no lookup accepted while streaming
    a_r6_busy_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        uop_valid_o |-> !lk_ready_o);
    // R2, R4: a hit starts the stream at the first micro-op
    a_r2_hit_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dec_off_o |-> (uop_valid_o && beat_q == '0));
    // R3: a miss presents nothing
    a_r3_miss_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (res_valid_o && !dec_off_o) |-> !uop_valid_o);
endmodule

// File: rtl/uop_cache.sv
module uop_cache #(
    parameter int AW     = 16,
    parameter int IDX_W  = 4,
    parameter int LINE_W = 2,
    parameter int UW     = 16,
    parameter int MAXU   = 4,
    parameter int CNT_W  = $clog2(MAXU)
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 flush_i,
    input  logic                 lk_valid_i,
    output logic                 lk_ready_o,
    input  logic [AW-1:0]        lk_addr_i,
    output logic                 res_valid_o,
    output logic                 dec_off_o,
    input  logic                 fill_valid_i,
    input  logic [AW-1:0]        fill_addr_i,
    input  logic [CNT_W-1:0]     fill_cnt_i,
    input  logic [MAXU*UW-1:0]   fill_uops_i,
    input  logic                 evict_valid_i,
    input  logic [AW-LINE_W-1:0] evict_line_i,
    output logic                 uop_valid_o,
    input  logic                 uop_ready_i,
    output logic [UW-1:0]        uop_data_o,
    output logic                 uop_last_o
);
    logic               lk_fire, hit;
    logic [CNT_W-1:0]   hit_cnt;
    logic [MAXU*UW-1:0] hit_uops;

    uopc_array #(
        .AW(AW), .IDX_W(IDX_W), .LINE_W(LINE_W), .UW(UW), .MAXU(MAXU), .CNT_W(CNT_W)
    ) array_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i),
        .evict_valid_i(evict_valid_i), .evict_line_i(evict_line_i),
        .fill_valid_i(fill_valid_i), .fill_addr_i(fill_addr_i),
        .fill_cnt_i(fill_cnt_i), .fill_uops_i(fill_uops_i),
        .lk_fire_i(lk_fire), .lk_addr_i(lk_addr_i),
        .hit_o(hit), .hit_cnt_o(hit_cnt), .hit_uops_o(hit_uops)
    );

    uopc_stream #(.UW(UW), .MAXU(MAXU), .CNT_W(CNT_W)) stream_i (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .lk_valid_i(lk_valid_i), .lk_ready_o(lk_ready_o), .lk_fire_o(lk_fire),
        .hit_i(hit), .hit_cnt_i(hit_cnt), .hit_uops_i(hit_uops),
        .res_valid_o(res_valid_o), .dec_off_o(dec_off_o),
        .uop_valid_o(uop_valid_o), .uop_ready_i(uop_ready_i),
        .uop_data_o(uop_data_o), .uop_last_o(uop_last_o)
    );

    // R9: a lookup colliding with a fill to its index reports a miss
    a_r9_fill_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lk_valid_i && lk_ready_o && fill_valid_i && fill_addr_i[IDX_W-1:0] == lk_addr_i[IDX_W-1:0])
        |=> (res_valid_o && !dec_off_o));
    // R10: a lookup in a flush cycle reports a miss
    a_r10_flush_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lk_valid_i && lk_ready_o && flush_i) |=> (res_valid_o && !dec_off_o));
endmodule

// File: tb/uop_cache_tb_top.sv
module uop_cache_tb_top;
    localparam int AW = 16, IDX_W = 4, LINE_W = 2, UW = 16, MAXU = 4, CNT_W = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0, lk_valid = 1'b0, fill_valid = 1'b0, evict_valid = 1'b0, uop_ready = 1'b1;
    logic [AW-1:0] lk_addr = '0, fill_addr = '0;
    logic [CNT_W-1:0] fill_cnt = '0;
    logic [MAXU*UW-1:0] fill_uops = '0;
    logic [AW-LINE_W-1:0] evict_line = '0;
    logic lk_ready, res_valid, dec_off, uop_valid, uop_last;
    logic [UW-1:0] uop_data;

    int errors = 0, checks = 0;
    int rdy_cnt = 0;
    bit stall_mode = 1'b0;
    logic [UW:0] expq[$];
    bit held = 1'b0;
    logic [UW:0] held_val;

    always #5 clk = ~clk;

    uop_cache #(.AW(AW), .IDX_W(IDX_W), .LINE_W(LINE_W), .UW(UW), .MAXU(MAXU)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
        .lk_valid_i(lk_valid), .lk_ready_o(lk_ready), .lk_addr_i(lk_addr),
        .res_valid_o(res_valid), .dec_off_o(dec_off),
        .fill_valid_i(fill_valid), .fill_addr_i(fill_addr), .fill_cnt_i(fill_cnt), .fill_uops_i(fill_uops),
        .evict_valid_i(evict_valid), .evict_line_i(evict_line),
        .uop_valid_o(uop_valid), .uop_ready_i(uop_ready), .uop_data_o(uop_data), .uop_last_o(uop_last)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [UW-1:0] mk_uop(input logic [AW-1:0] a, input int j, input logic [3:0] gen);
        return {gen, a[7:0], 2'(j), 2'b01};
    endfunction

    // Ready pattern driven away from the edge
    always @(posedge clk) begin
        #2;
        rdy_cnt++;
        uop_ready = stall_mode ? (rdy_cnt % 3 == 2) : 1'b1;
    end

    // Monitor: compare transfers against the scoreboard, and held values under stall (R4, R5)
    always @(negedge clk) begin
        if (rst_n) begin
            if (held) begin
                check(uop_valid && {uop_last, uop_data} == held_val, "R5 stall hold",
                      {15'd0, uop_valid, uop_last, uop_data}, {16'd1, held_val});
                held = 1'b0;
            end
            if (uop_valid && uop_ready) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R5 extra micro-op", {15'd0, uop_last, uop_data}, 32'd0);
                end else begin
                    logic [UW:0] e;
                    e = expq.pop_front();
                    check({uop_last, uop_data} == e, "R4 micro-op order/last",
                          {15'd0, uop_last, uop_data}, {15'd0, e});
                end
            end else if (uop_valid && !uop_ready) begin
                held = 1'b1;
                held_val = {uop_last, uop_data};
            end
        end
    end

    task automatic do_fill(input logic [AW-1:0] a, input int n, input logic [3:0] gen);
        @(negedge clk);
        fill_valid = 1'b1;
        fill_addr  = a;
        fill_cnt   = CNT_W'(n - 1);
        for (int j = 0; j < MAXU; j++) fill_uops[j*UW +: UW] = mk_uop(a, j, gen);
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic do_lookup(input logic [AW-1:0] a, input bit exp_hit, input int n,
                             input logic [3:0] gen, input string req);
        @(negedge clk);
        while (!lk_ready) @(negedge clk);
        lk_valid = 1'b1;
        lk_addr  = a;
        @(posedge clk);
        #1;
        lk_valid = 1'b0;
        check(res_valid && dec_off == exp_hit, req, {30'd0, res_valid, dec_off}, {30'd0, 1'b1, exp_hit});
        if (exp_hit) begin
            for (int j = 0; j < n; j++) expq.push_back({(j == n - 1), mk_uop(a, j, gen)});
        end else begin
            check(!uop_valid, "R3 miss presents nothing", {31'd0, uop_valid}, 32'd0);
        end
        @(negedge clk);
        while (expq.size() != 0 || !lk_ready) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check(lk_ready && !uop_valid && !res_valid, "R11 reset outputs",
              {29'd0, lk_ready, uop_valid, res_valid}, 32'd4);
        rst_n = 1'b1;
        @(negedge clk);
        check(lk_ready && !uop_valid && !res_valid, "R11 idle after reset",
              {29'd0, lk_ready, uop_valid, res_valid}, 32'd4);

        // R3: empty cache misses
        do_lookup(16'h0010, 1'b0, 0, 4'h0, "R3 miss on empty cache");

        // R2, R4: four micro-ops; R6 checked mid-stream
        do_fill(16'h0010, 4, 4'h1);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = 16'h0010;
        @(posedge clk); #1; lk_valid = 1'b0;
        check(res_valid && dec_off, "R2 hit turns decoder off", {30'd0, res_valid, dec_off}, 32'd3);
        for (int j = 0; j < 4; j++) expq.push_back({(j == 3), mk_uop(16'h0010, j, 4'h1)});
        @(negedge clk);
        check(!lk_ready, "R6 lookup blocked while streaming", {31'd0, lk_ready}, 32'd0);
        while (expq.size() != 0 || !lk_ready) @(negedge clk);

        // R5: single micro-op and multi micro-op under stalls
        stall_mode = 1'b1;
        do_fill(16'h0021, 1, 4'h2);
        do_lookup(16'h0021, 1'b1, 1, 4'h2, "R2 hit single micro-op");
        do_fill(16'h0022, 3, 4'h3);
        do_lookup(16'h0022, 1'b1, 3, 4'h3, "R5 hit under stalls");
        stall_mode = 1'b0;

        // R1: aliasing fill replaces the entry
        do_fill(16'h0110, 2, 4'h4);
        do_lookup(16'h0010, 1'b0, 0, 4'h0, "R1 aliased address misses");
        do_lookup(16'h0110, 1'b1, 2, 4'h4, "R1 new address hits");

        // R7: evict line 0x10 (addresses 0x40..0x43), keep 0x44
        do_fill(16'h0040, 1, 4'h5);
        do_fill(16'h0041, 2, 4'h5);
        do_fill(16'h0043, 3, 4'h5);
        do_fill(16'h0044, 4, 4'h5);
        @(negedge clk);
        evict_valid = 1'b1; evict_line = 14'h0010;
        @(negedge clk);
        evict_valid = 1'b0;
        do_lookup(16'h0040, 1'b0, 0, 4'h0, "R7 evicted entry 0x40 misses");
        do_lookup(16'h0041, 1'b0, 0, 4'h0, "R7 evicted entry 0x41 misses");
        do_lookup(16'h0043, 1'b0, 0, 4'h0, "R7 evicted entry 0x43 misses");
        do_lookup(16'h0044, 1'b1, 4, 4'h5, "R7 other line survives");

        // R9: lookup and fill to the same index in one cycle
        @(negedge clk);
        fill_valid = 1'b1; fill_addr = 16'h0055; fill_cnt = 2'd1;
        for (int j = 0; j < MAXU; j++) fill_uops[j*UW +: UW] = mk_uop(16'h0055, j, 4'h6);
        lk_valid = 1'b1; lk_addr = 16'h0055;
        @(posedge clk); #1;
        lk_valid = 1'b0; fill_valid = 1'b0;
        check(res_valid && !dec_off, "R9 colliding lookup misses", {30'd0, res_valid, dec_off}, 32'd2);
        do_lookup(16'h0055, 1'b1, 2, 4'h6, "R9 fill stored");

        // R8: flush clears everything
        do_fill(16'h0030, 2, 4'h7);
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        do_lookup(16'h0030, 1'b0, 0, 4'h0, "R8 flushed entry misses");
        do_lookup(16'h0044, 1'b0, 0, 4'h0, "R8 older entry flushed");

        // R10: lookup during flush misses
        do_fill(16'h0077, 1, 4'h8);
        @(negedge clk);
        flush = 1'b1; lk_valid = 1'b1; lk_addr = 16'h0077;
        @(posedge clk); #1;
        flush = 1'b0; lk_valid = 1'b0;
        check(res_valid && !dec_off, "R10 lookup in flush cycle misses", {30'd0, res_valid, dec_off}, 32'd2);

        // R10: eviction overrides same-cycle fill in the evicted line (0x62 in line 0x18)
        @(negedge clk);
        fill_valid = 1'b1; fill_addr = 16'h0062; fill_cnt = 2'd0;
        for (int j = 0; j < MAXU; j++) fill_uops[j*UW +: UW] = mk_uop(16'h0062, j, 4'h9);
        evict_valid = 1'b1; evict_line = 14'h0018;
        @(negedge clk);
        fill_valid = 1'b0; evict_valid = 1'b0;
        do_lookup(16'h0062, 1'b0, 0, 4'h0, "R10 eviction beats fill");

        // R10: lookup in the same cycle as a covering eviction misses
        do_fill(16'h0065, 2, 4'hA);
        @(negedge clk);
        evict_valid = 1'b1; evict_line = 14'h0019; lk_valid = 1'b1; lk_addr = 16'h0065;
        @(posedge clk); #1;
        evict_valid = 1'b0; lk_valid = 1'b0;
        check(res_valid && !dec_off, "R10 lookup in eviction cycle misses", {30'd0, res_valid, dec_off}, 32'd2);

        repeat (4) @(negedge clk);
        check(expq.size() == 0 && !uop_valid, "R5 no missing or extra micro-ops",
              expq.size(), 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule